// File: doc/BRIEF.md
# Interleave Capability Checker

This block decides whether a memory decoder can carry a requested interleave setup. It takes a capability word, a way count, a granularity in bytes and a passthrough flag. The way count and the granularity are turned into small encoded values. The block works out which way counts the capability word advertises and which host address bits it allows for target selection. It then finds the host address bits that the request would use to pick a target. The request is legal only when every one of those bits is advertised as usable.

Software-side configuration logic issues a one-cycle `start` pulse with the request held on the inputs. One clock later the block returns the verdict on `res_ok`, marked by a one-cycle `res_valid` strobe. The interface has no back-pressure. A result cannot be stalled, so the consumer must take `res_valid` in the cycle it is high. `res_ok` keeps the last verdict until the next `start`.

Top module: `ilv_cap_check`

## Requirements
- R1: A way count is encodable only if it is 1, 2, 4, 8 or 16 (codes 0, 1, 2, 3, 4) or 3, 6 or 12 (codes 8, 9, 10). Any other way count, including 0, gives a reject in every mode.
- R2: A granularity is encodable only if it is a power of two from 256 to 16384 bytes, with code log2(bytes) − 8. Any other granularity gives a reject in every mode.
- R3: When not in passthrough, a way count of 3, 6 or 12 is rejected unless capability bit 11 is set.
- R4: When not in passthrough, a way count of 16 is rejected unless capability bit 12 is set. Way counts 1, 2, 4 and 8 never depend on capability bits.
- R5: A way count of 1 or 3 (codes 0 and 8) uses no host address bits. It is accepted whenever its way count and granularity are supported.
- R6: For the other way counts, the selection bits run from (granularity code + 8) up to (ways code + granularity code + 7) when the ways code is below 8, and up to (ways code + granularity code − 1) when it is above 8. Capability bit 8 allows bits 8 to 11 and capability bit 9 allows bits 12 to 14. No other bit is allowed, and the request is rejected if any selection bit is not allowed.
- R7: In passthrough mode every encodable way count and granularity pair is accepted, whatever the capability word holds.
- R8: `res_valid` is high in exactly the cycle after each cycle in which `start` is high. `res_ok` changes only in a cycle that follows a `start`, and holds otherwise.
- R9: Synchronous reset, active high, clears `res_valid` and `res_ok` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request pulse; the request inputs are sampled with it |
| cap_word | input | 16 | Decoder capability word (bits 8, 9, 11 and 12 are decoded) |
| ways | input | 5 | Requested number of interleave ways |
| gran_bytes | input | 16 | Requested interleave granularity in bytes |
| passthru | input | 1 | Treat all way counts and address bits as supported |
| res_valid | output | 1 | One-cycle strobe marking a new verdict |
| res_ok | output | 1 | Verdict: 1 accepts the request, 0 rejects it |

## Verification
Every verdict is registered one edge after its `start`, so an internal fault shows up on `res_ok` in the very next cycle. Examples are a wrong ways or granularity code, a swapped capability bit, or a selection range that is off by one. A range error appears only in the capability combinations where the edge bit (11/12 or 14/15) decides the result. For that reason the sweep crosses every way count from 0 to 17 and a spread of legal and illegal granularities with all sixteen settings of the four decoded capability bits, in both modes. A strobe or hold fault shows up as `res_valid` or `res_ok` being wrong in the cycle after the strobe.

// File: rtl/ilv_cap_pkg.sv
package ilv_cap_pkg;
  // Capability word bit positions decoded by the checker
  localparam int CAP_ADDR_LO_GRP = 8;   // host bits 8..11 usable
  localparam int CAP_ADDR_HI_GRP = 9;   // host bits 12..14 usable
  localparam int CAP_WAYS_3X     = 11;  // 3, 6, 12 ways
  localparam int CAP_WAYS_16     = 12;  // 16 ways

  // Host address bit groups
  localparam int GRP_LO_FIRST = 8;
  localparam int GRP_LO_LAST  = 11;
  localparam int GRP_HI_FIRST = 12;
  localparam int GRP_HI_LAST  = 14;

  localparam int WCODE_W = 4;
  localparam int GCODE_W = 3;
  localparam int POS_W   = 6;

  typedef struct packed {
    logic               legal;
    logic [WCODE_W-1:0] code;
  } wcode_t;

  typedef struct packed {
    logic               legal;
    logic [GCODE_W-1:0] code;
  } gcode_t;
endpackage

// File: rtl/ilv_ways_enc.sv
module ilv_ways_enc
  import ilv_cap_pkg::*;
#(
  parameter int WAYS_W = 5
) (
  input  logic [WAYS_W-1:0] ways,
  output wcode_t            enc
);
  always_comb begin
    enc = '0;
    case (int'(ways))
      1:  enc = '{legal: 1'b1, code: 4'd0};
      2:  enc = '{legal: 1'b1, code: 4'd1};
      4:  enc = '{legal: 1'b1, code: 4'd2};
      8:  enc = '{legal: 1'b1, code: 4'd3};
      16: enc = '{legal: 1'b1, code: 4'd4};
      3:  enc = '{legal: 1'b1, code: 4'd8};
      6:  enc = '{legal: 1'b1, code: 4'd9};
      12: enc = '{legal: 1'b1, code: 4'd10};
      default: enc = '0;
    endcase
  end
endmodule

// File: rtl/ilv_gran_enc.sv
module ilv_gran_enc
  import ilv_cap_pkg::*;
#(
  parameter int GRAN_W  = 16,
  parameter int MIN_LOG = 8,
  parameter int MAX_LOG = 14
) (
  input  logic [GRAN_W-1:0] gran_bytes,
  output gcode_t            enc
);
  logic [MAX_LOG-MIN_LOG:0] hit;

  for (genvar p = MIN_LOG; p <= MAX_LOG; p++) begin : g_pow
    assign hit[p-MIN_LOG] = (gran_bytes == GRAN_W'(1) << p);
  end

  always_comb begin
    enc = '0;
    for (int i = 0; i <= MAX_LOG - MIN_LOG; i++) begin
      if (hit[i]) begin
        enc.legal = 1'b1;
        enc.code  = GCODE_W'(i);
      end
    end
  end
endmodule

// File: rtl/ilv_cap_masks.sv
module ilv_cap_masks
  import ilv_cap_pkg::*;
#(
  parameter int CAP_W   = 16,
  parameter int WMASK_W = 32,
  parameter int AMASK_W = 32
) (
  input  logic [CAP_W-1:0]   cap_word,
  input  logic               passthru,
  output logic [WMASK_W-1:0] ways_sup,
  output logic [AMASK_W-1:0] addr_sup
);
  logic unused_cap;
  assign unused_cap = ^cap_word;

  always_comb begin
    ways_sup = '0;
    addr_sup = '0;
    if (passthru) begin
      ways_sup = '1;
      addr_sup = '1;
    end else begin
      ways_sup[1] = 1'b1;
      ways_sup[2] = 1'b1;
      ways_sup[4] = 1'b1;
      ways_sup[8] = 1'b1;
      if (cap_word[CAP_WAYS_3X]) begin
        ways_sup[3]  = 1'b1;
        ways_sup[6]  = 1'b1;
        ways_sup[12] = 1'b1;
      end
      if (cap_word[CAP_WAYS_16]) ways_sup[16] = 1'b1;
      for (int b = GRP_LO_FIRST; b <= GRP_LO_LAST; b++)
        if (cap_word[CAP_ADDR_LO_GRP]) addr_sup[b] = 1'b1;
      for (int b = GRP_HI_FIRST; b <= GRP_HI_LAST; b++)
        if (cap_word[CAP_ADDR_HI_GRP]) addr_sup[b] = 1'b1;
    end
  end
endmodule

// File: rtl/ilv_range_chk.sv
module ilv_range_chk
  import ilv_cap_pkg::*;
#(
  parameter int AMASK_W = 32
) (
  input  logic [WCODE_W-1:0] wcode,
  input  logic [GCODE_W-1:0] gcode,
  input  logic [AMASK_W-1:0] addr_sup,
  output logic               range_ok
);
  logic [POS_W-1:0]   lo_pos;
  logic [POS_W-1:0]   hi_pos;
  logic [AMASK_W-1:0] sel_bits;
  logic               no_bits;

  assign no_bits = (wcode == WCODE_W'(0)) || (wcode == WCODE_W'(8));
  assign lo_pos  = POS_W'(gcode) + POS_W'(8);
  assign hi_pos  = (wcode > WCODE_W'(8))
                 ? POS_W'(wcode) + POS_W'(gcode) - POS_W'(1)
                 : POS_W'(wcode) + POS_W'(gcode) + POS_W'(7);

  for (genvar i = 0; i < AMASK_W; i++) begin : g_bit
    assign sel_bits[i] = (POS_W'(i) >= lo_pos) && (POS_W'(i) <= hi_pos);
  end

  assign range_ok = no_bits || ((sel_bits & ~addr_sup) == '0);
endmodule

// File: rtl/ilv_cap_check.sv
module ilv_cap_check
  import ilv_cap_pkg::*;
#(
  parameter int CAP_W   = 16,
  parameter int WAYS_W  = 5,
  parameter int GRAN_W  = 16,
  parameter int AMASK_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CAP_W-1:0]  cap_word,
  input  logic [WAYS_W-1:0] ways,
  input  logic [GRAN_W-1:0] gran_bytes,
  input  logic              passthru,
  output logic              res_valid,
  output logic              res_ok
);
  localparam int WMASK_W = 1 << WAYS_W;

  wcode_t             wenc;
  gcode_t             genc;
  logic [WMASK_W-1:0] ways_sup;
  logic [AMASK_W-1:0] addr_sup;
  logic               range_ok;
  logic               accept;

  ilv_ways_enc #(.WAYS_W(WAYS_W)) u_ways (
    .ways (ways),
    .enc  (wenc)
  );

  ilv_gran_enc #(.GRAN_W(GRAN_W), .MIN_LOG(8), .MAX_LOG(14)) u_gran (
    .gran_bytes (gran_bytes),
    .enc        (genc)
  );

  ilv_cap_masks #(.CAP_W(CAP_W), .WMASK_W(WMASK_W), .AMASK_W(AMASK_W)) u_masks (
    .cap_word (cap_word),
    .passthru (passthru),
    .ways_sup (ways_sup),
    .addr_sup (addr_sup)
  );

  ilv_range_chk #(.AMASK_W(AMASK_W)) u_range (
    .wcode    (wenc.code),
    .gcode    (genc.code),
    .addr_sup (addr_sup),
    .range_ok (range_ok)
  );

  assign accept = wenc.legal && genc.legal && ways_sup[ways] && range_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_ok    <= 1'b0;
    end else begin
      res_valid <= start;
      if (start) res_ok <= accept;
    end
  end
endmodule

// File: rtl/ilv_cap_check_sva.sv
module ilv_cap_check_sva #(
  parameter int CAP_W  = 16,
  parameter int WAYS_W = 5,
  parameter int GRAN_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [CAP_W-1:0]  cap_word,
  input logic [WAYS_W-1:0] ways,
  input logic [GRAN_W-1:0] gran_bytes,
  input logic              passthru,
  input logic              res_valid,
  input logic              res_ok
);
  logic ways_3x, ways_enc_ok, gran_enc_ok;
  assign ways_3x     = (ways == 5'd3) || (ways == 5'd6) || (ways == 5'd12);
  assign ways_enc_ok = ways_3x || (ways == 5'd1) || (ways == 5'd2) ||
                       (ways == 5'd4) || (ways == 5'd8) || (ways == 5'd16);
  assign gran_enc_ok = ($countones(gran_bytes) == 1) &&
                       (gran_bytes >= GRAN_W'(256)) && (gran_bytes <= GRAN_W'(16384));

  AST_VALID_FOLLOWS_START: assert property (@(posedge clk) disable iff (rst)
    !start |=> !res_valid); // R8
  AST_START_GIVES_VALID: assert property (@(posedge clk) disable iff (rst)
    start |=> res_valid); // R8
  AST_OK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(res_ok)); // R8
  AST_BAD_WAYS: assert property (@(posedge clk) disable iff (rst)
    (start && !ways_enc_ok) |=> !res_ok); // R1
  AST_BAD_GRAN: assert property (@(posedge clk) disable iff (rst)
    (start && !gran_enc_ok) |=> !res_ok); // R2
  AST_NO_CAP_3X: assert property (@(posedge clk) disable iff (rst)
    (start && !passthru && !cap_word[11] && ways_3x) |=> !res_ok); // R3
  AST_NO_CAP_16: assert property (@(posedge clk) disable iff (rst)
    (start && !passthru && !cap_word[12] && ways == 5'd16) |=> !res_ok); // R4
  AST_PASSTHRU_OK: assert property (@(posedge clk) disable iff (rst)
    (start && passthru && ways_enc_ok && gran_enc_ok) |=> res_ok); // R7
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!res_valid && !res_ok)); // R9
endmodule

bind ilv_cap_check ilv_cap_check_sva #(
  .CAP_W(CAP_W), .WAYS_W(WAYS_W), .GRAN_W(GRAN_W)
) u_sva (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .cap_word   (cap_word),
  .ways       (ways),
  .gran_bytes (gran_bytes),
  .passthru   (passthru),
  .res_valid  (res_valid),
  .res_ok     (res_ok)
);

// File: tb/test_ilv_cap_check.sv
`timescale 1ns/1ps
module test_ilv_cap_check;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] cap_word = '0;
  logic [4:0]  ways = '0;
  logic [15:0] gran_bytes = '0;
  logic        passthru = 1'b0;
  logic        res_valid;
  logic        res_ok;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  ilv_cap_check i_ilv_cap_check (
    .clk(clk), .rst(rst), .start(start), .cap_word(cap_word), .ways(ways),
    .gran_bytes(gran_bytes), .passthru(passthru),
    .res_valid(res_valid), .res_ok(res_ok)
  );

  task automatic check(string req, logic act, logic exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b (ways=%0d gran=%0d cap=%h pt=%b)",
               req, what, act, exp, ways, gran_bytes, cap_word, passthru);
    end
  endtask

  // Expected verdict, worked out as a host bit range starting at log2(gran)
  function automatic bit model(logic [15:0] cw, int w, int g, bit pt, output string req);
    int lg = -1, nb = -1;
    bit need3 = 0, need16 = 0;
    for (int p = 8; p <= 14; p++) if (g == (1 << p)) lg = p;
    for (int j = 0; j <= 4; j++) if (w == (1 << j)) nb = j;
    for (int j = 0; j <= 2; j++) if (w == (3 << j)) begin nb = j; need3 = 1; end
    if (w == 16) need16 = 1;
    if (nb < 0) begin req = "R1"; return 0; end
    if (lg < 0) begin req = "R2"; return 0; end
    if (pt) begin req = "R7"; return 1; end
    if (need3) begin
      req = "R3";
      if (!cw[11]) return 0;
    end
    if (need16) begin
      req = "R4";
      if (!cw[12]) return 0;
    end
    if (nb == 0) begin req = "R5"; return 1; end
    if (!need3 && !need16) req = "R6";
    for (int b = lg; b < lg + nb; b++) begin
      if (!((b >= 8 && b <= 11 && cw[8]) || (b >= 12 && b <= 14 && cw[9])))
        return 0;
    end
    return 1;
  endfunction

  task automatic apply(logic [15:0] cw, int w, int g, bit pt);
    string req;
    bit exp;
    exp = model(cw, w, g, pt, req);
    @(negedge clk);
    cap_word = cw; ways = 5'(w); gran_bytes = 16'(g); passthru = pt; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R8", res_valid, 1'b1, "strobe after start");
    check(req, res_ok, exp, "verdict");
    @(negedge clk);
    check("R8", res_valid, 1'b0, "strobe one cycle");
    check("R8", res_ok, exp, "verdict held");
  endtask

  initial begin
    int grans[13] = '{0, 128, 255, 256, 512, 768, 1024, 2048, 4096, 8192,
                      16384, 32768, 16385};
    logic [15:0] cw;
    repeat (3) @(negedge clk);
    check("R9", res_valid, 1'b0, "valid after reset");
    check("R9", res_ok, 1'b0, "ok after reset");
    rst = 1'b0;
    for (int c = 0; c < 16; c++) begin
      for (int pt = 0; pt < 2; pt++) begin
        for (int w = 0; w < 18; w++) begin
          for (int gi = 0; gi < 13; gi++) begin
            cw = 16'h2085 ^ {3'b0, c[3], c[2], 1'b0, c[1], c[0], 8'h00};
            apply(cw, w, grans[gi], pt[0]);
          end
        end
      end
    end
    // R9: reset mid-run clears a held accept
    apply(16'h0000, 1, 256, 1'b0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R9", res_valid, 1'b0, "valid cleared by reset");
    check("R9", res_ok, 1'b0, "ok cleared by reset");
    rst = 1'b0;
    done = 1'b1;
  end

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
      wait (done);
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule